// File: doc/BRIEF.md
# Reference Divider and Phase-Frequency Comparator

This block sits at the reference side of a frequency synthesiser loop. It divides its own clock (the reference clock) by twice a programmed ratio to make a one-cycle divided-reference pulse. It then compares the timing of that pulse against a one-cycle feedback pulse from the main divider chain. The comparison drives a coarse error output with three states: pump up, pump down, or released. The released state is carried as a separate drive level and drive enable, so the pad logic can build a true three-state buffer from them.

A lock flag models an open-drain pin. It asks for the pin to be pulled low once the two edges have landed within a programmable distance of each other, counted in reference clock cycles, for a set number of comparisons in a row. While the loop holds inside that window, the coarse output stays released. As soon as a pulse grows past the window, the coarse output drives again and the lock flag lets go, both in the same cycle.

A new ratio can be loaded at any time. It is held aside and only takes effect at the end of the divided period in progress, so no period is ever shortened or stretched mid-way. A load below the legal minimum is dropped.

Top module: `refdiv_pfd`

## Requirements
- R1: While the ratio is R, `ref_pulse_o` is high for exactly one cycle in every 2·R clock cycles.
- R2: A ratio accepted on `ratio_ld_i` leaves the divided period in progress unchanged. Every period after the next pulse is 2·(new R).
- R3: A load with a ratio below 3 is ignored, and the period stays at its previous length. Any value from 3 up to 2^RATIO_W−1 (2047 by default) is accepted.
- R4: When the feedback edge leads the reference edge, or the feedback frequency is higher, the coarse output pumps up (`err_drive_o`=1 with `err_en_o`=1) whenever it is not held released by lock.
- R5: When the reference edge leads, or the reference frequency is higher, the coarse output pumps down (`err_drive_o`=0 with `err_en_o`=1) whenever it is not held released by lock.
- R6: Up and down are never active together. The edge that answers a pending pulse ends it in the cycle that edge is sampled. Edges sampled in the same cycle produce no pulse at all.
- R7: `lock_pull_o` rises only after LOCK_COUNT consecutive comparisons whose edge distance is at most WIN_CYC cycles. Coincident edges count as distance 0. One good comparison from an unlocked state is not enough when LOCK_COUNT is 2.
- R8: While locked, a pulse whose length has not exceeded WIN_CYC cycles keeps `err_en_o` low.
- R9: In the pulse cycle numbered WIN_CYC+1, `err_en_o` goes high and `lock_pull_o` goes low together. The comparison counts as bad, and the lock run restarts from zero.
- R10: After reset, `ref_pulse_o`, `err_en_o` and `lock_pull_o` are all low, and the ratio is RESET_RATIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ratio_i | input | RATIO_W | Ratio R to load (divide by 2·R) |
| ratio_ld_i | input | 1 | One-cycle load strobe for `ratio_i` |
| fb_pulse_i | input | 1 | One-cycle feedback pulse from the main divider |
| ref_pulse_o | output | 1 | One-cycle divided-reference pulse |
| err_drive_o | output | 1 | Coarse error level: 1 pump up, 0 pump down |
| err_en_o | output | 1 | Coarse error drive enable; 0 means released |
| lock_pull_o | output | 1 | 1 asks the open-drain lock pin to pull low |

## Verification
A reference pulse is visible in the cycle after the divider reaches its terminal count. Pulse-to-pulse spacing is therefore checked by a scoreboard monitor that times successive pulses against expected periods queued by the load driver. A pulse edge sampled at clock edge t shows on `err_en_o`/`err_drive_o` from the cycle after t. Lock changes appear in the cycle after the completing edge. The window overrun acts on the outputs combinationally, in the (WIN_CYC+1)th pulse cycle. Every phase check counts falling edges from the one on which the reference pulse was seen, drives the feedback pulse on a chosen falling edge, and samples outputs on the falling edge where each result is due.

// File: rtl/refpfd_pkg.sv
package refpfd_pkg;
   // smallest accepted ratio; 2*R must leave room for a low cycle between pulses
   localparam int unsigned RATIO_MIN = 3;

   // pending comparator direction
   typedef struct packed {
      logic up;
      logic dn;
   } pfd_state_t;
endpackage

// File: rtl/refdiv_core.sv
module refdiv_core
   import refpfd_pkg::*;
#(
   parameter int unsigned RATIO_W     = 11,
   parameter int unsigned RESET_RATIO = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               ratio_ld_i,
   output logic               ref_pulse_o
);
   localparam int unsigned CNT_W = RATIO_W + 1;

   initial begin
      assert (RATIO_W >= 2) else $error("RATIO_W too small for minimum ratio");
      assert (RESET_RATIO >= RATIO_MIN && RESET_RATIO < (2 ** RATIO_W))
         else $error("RESET_RATIO out of range");
   end

   logic [RATIO_W-1:0] cur_q, pend_q;
   logic [CNT_W-1:0]   cnt_q, term_c;
   logic               hit_c, ld_ok_c;

   always_comb begin
      term_c  = {cur_q, 1'b0} - CNT_W'(1);
      hit_c   = (cnt_q == term_c);
      ld_ok_c = ratio_ld_i && (ratio_i >= RATIO_W'(RATIO_MIN));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q       <= '0;
         cur_q       <= RATIO_W'(RESET_RATIO);
         pend_q      <= RATIO_W'(RESET_RATIO);
         ref_pulse_o <= 1'b0;
      end else begin
         ref_pulse_o <= hit_c;
         if (hit_c) begin
            cnt_q <= '0;
            cur_q <= pend_q;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
         if (ld_ok_c) pend_q <= ratio_i;
      end
   end

   a_r1_single_pulse : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_pulse_o |=> !ref_pulse_o);
   a_r2_switch_at_terminal : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cur_q) |-> $past(hit_c));
   a_r3_short_load_dropped : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ratio_ld_i && ratio_i < RATIO_W'(RATIO_MIN)) |=> $stable(pend_q));
endmodule

// File: rtl/refpfd_detector.sv
module refpfd_detector
   import refpfd_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ref_i,
   input  logic       fb_i,
   output pfd_state_t state_o,
   output logic       pair_o
);
   pfd_state_t st_q, st_d;
   logic       up_side_c, dn_side_c;

   always_comb begin
      up_side_c = st_q.up | fb_i;
      dn_side_c = st_q.dn | ref_i;
      pair_o    = up_side_c & dn_side_c;
      st_d.up   = up_side_c & ~dn_side_c;
      st_d.dn   = dn_side_c & ~up_side_c;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= '0;
      else         st_q <= st_d;
   end

   assign state_o = st_q;

   a_r6_up_ends_on_ref : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q.up && ref_i) |=> (!st_q.up && !st_q.dn));
   a_r6_dn_ends_on_fb : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q.dn && fb_i) |=> (!st_q.up && !st_q.dn));
   a_r4_fb_first_raises_up : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fb_i && !ref_i && !st_q.dn) |=> st_q.up);
endmodule

// File: rtl/refpfd_lockwin.sv
module refpfd_lockwin #(
   parameter int unsigned WIN_CYC    = 4,
   parameter int unsigned LOCK_COUNT = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pulse_i,
   input  logic pair_i,
   output logic lock_o,
   output logic overrun_o
);
   localparam int unsigned W_W = $clog2(WIN_CYC + 1);

   initial begin
      assert (WIN_CYC >= 1) else $error("WIN_CYC must be at least 1");
      assert (LOCK_COUNT >= 1) else $error("LOCK_COUNT must be at least 1");
   end

   logic [W_W-1:0] w_q;
   logic           good_c;

   always_comb begin
      overrun_o = pulse_i && (w_q >= W_W'(WIN_CYC));
      good_c    = pair_i && !overrun_o;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      w_q <= '0;
      else if (!pulse_i || pair_i)      w_q <= '0;
      else if (w_q < W_W'(WIN_CYC))     w_q <= w_q + W_W'(1);
   end

   if (LOCK_COUNT == 1) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        lock_o <= 1'b0;
         else if (overrun_o) lock_o <= 1'b0;
         else if (good_c)    lock_o <= 1'b1;
      end
   end else begin : g_run
      localparam int unsigned OK_W = $clog2(LOCK_COUNT + 1);
      logic [OK_W-1:0] ok_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                       ok_q <= '0;
         else if (overrun_o)                                ok_q <= '0;
         else if (good_c && ok_q < OK_W'(LOCK_COUNT))       ok_q <= ok_q + OK_W'(1);
      end
      assign lock_o = (ok_q == OK_W'(LOCK_COUNT));
   end

   a_r7_lock_after_pair : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_o) |-> $past(pair_i));
   a_r9_overrun_unlocks : assert property (@(posedge clk_i) disable iff (!rst_ni)
      overrun_o |=> !lock_o);
endmodule

// File: rtl/refdiv_pfd.sv
module refdiv_pfd
   import refpfd_pkg::*;
#(
   parameter int unsigned RATIO_W     = 11,
   parameter int unsigned RESET_RATIO = 8,
   parameter int unsigned WIN_CYC     = 4,
   parameter int unsigned LOCK_COUNT  = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               ratio_ld_i,
   input  logic               fb_pulse_i,
   output logic               ref_pulse_o,
   output logic               err_drive_o,
   output logic               err_en_o,
   output logic               lock_pull_o
);
   pfd_state_t st_w;
   logic       pair_w, lock_w, overrun_w, pulse_w;

   refdiv_core #(
      .RATIO_W    (RATIO_W),
      .RESET_RATIO(RESET_RATIO)
   ) u_div (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ratio_i    (ratio_i),
      .ratio_ld_i (ratio_ld_i),
      .ref_pulse_o(ref_pulse_o)
   );

   refpfd_detector u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ref_i  (ref_pulse_o),
      .fb_i   (fb_pulse_i),
      .state_o(st_w),
      .pair_o (pair_w)
   );

   assign pulse_w = st_w.up | st_w.dn;

   refpfd_lockwin #(
      .WIN_CYC   (WIN_CYC),
      .LOCK_COUNT(LOCK_COUNT)
   ) u_lock (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pulse_i  (pulse_w),
      .pair_i   (pair_w),
      .lock_o   (lock_w),
      .overrun_o(overrun_w)
   );

   always_comb begin
      err_drive_o = st_w.up;
      err_en_o    = pulse_w && (!lock_w || overrun_w);
      lock_pull_o = lock_w && !overrun_w;
   end

   a_r8_released_while_locked : assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_pull_o |-> !err_en_o);
   a_r5_ref_first_drives_down : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ref_pulse_o && !fb_pulse_i && !st_w.up && !lock_w) |=> (err_en_o && !err_drive_o));
endmodule

// File: tb/refdiv_pfd_tb_top.sv
module refdiv_pfd_tb_top;
   localparam int RATIO_W = 11;
   localparam int R0      = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [RATIO_W-1:0] ratio = '0;
   logic               ld = 1'b0;
   logic               fb = 1'b0;
   logic               ref_pulse_o, err_drive_o, err_en_o, lock_pull_o;

   int n_chk = 0;
   int n_fail = 0;
   int rel = 0;
   int cyc = 0;
   int prev_cyc = 0;
   bit have_prev = 0;
   int    exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   refdiv_pfd #(.RATIO_W(RATIO_W), .RESET_RATIO(R0), .WIN_CYC(4), .LOCK_COUNT(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .ratio_ld_i(ld),
      .fb_pulse_i(fb), .ref_pulse_o(ref_pulse_o), .err_drive_o(err_drive_o),
      .err_en_o(err_en_o), .lock_pull_o(lock_pull_o));

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // scoreboard monitor: times successive reference pulses
   always @(negedge clk) begin
      cyc++;
      if (rst_n && ref_pulse_o === 1'b1) begin
         if (have_prev && exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (cyc - prev_cyc != e) begin
               n_fail++;
               $display("FAIL %s: actual period %0d expected %0d", t, cyc - prev_cyc, e);
            end
         end
         prev_cyc  = cyc;
         have_prev = 1;
      end
   end

   task automatic push_exp(input int p, input string t);
      exp_q.push_back(p);
      tag_q.push_back(t);
   endtask

   task automatic wait_ref();
      @(negedge clk);
      while (ref_pulse_o !== 1'b1) @(negedge clk);
      rel = 0;
   endtask

   task automatic step_to(input int k);
      while (rel < k) begin
         @(negedge clk);
         rel++;
      end
   endtask

   task automatic fb_at(input int m);
      step_to(m);
      fb = 1'b1;
      step_to(m + 1);
      fb = 1'b0;
   endtask

   task automatic load_ratio(input int r, input int old_p, input int new_p, input string t);
      wait_ref();
      @(negedge clk);
      ratio = RATIO_W'(r);
      ld    = 1'b1;
      push_exp(old_p, t);
      push_exp(new_p, t);
      push_exp(new_p, t);
      @(negedge clk);
      ld = 1'b0;
      while (exp_q.size() > 0) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 ref_pulse", ref_pulse_o, 1'b0);
      chk("R10 err_en", err_en_o, 1'b0);
      chk("R10 lock_pull", lock_pull_o, 1'b0);
      // R1: reset ratio gives period 2*R0
      for (int i = 0; i < 3; i++) push_exp(2 * R0, "R1");

      // lag 2, unlocked: pump down; one good comparison is not lock
      wait_ref();
      fb_at(2);
      step_to(1);
      step_to(3);
      chk("R7 one good not locked", lock_pull_o, 1'b0);
      wait_ref();
      step_to(1);
      chk("R5 lag en", err_en_o, 1'b1);
      chk("R5 lag down", err_drive_o, 1'b0);
      fb_at(2);
      step_to(3);
      chk("R7 locked after two", lock_pull_o, 1'b1);
      // lag 3 while locked: released
      wait_ref();
      fb_at(3);
      rel = 0;
      wait_ref();
      step_to(1);
      chk("R8 released rel1", err_en_o, 1'b0);
      step_to(2);
      chk("R8 released rel2", err_en_o, 1'b0);
      chk("R8 lock held", lock_pull_o, 1'b1);
      fb_at(3);
      // lag 6: overrun in pulse cycle 5
      wait_ref();
      step_to(4);
      chk("R8 within window", err_en_o, 1'b0);
      step_to(5);
      chk("R9 overrun en", err_en_o, 1'b1);
      chk("R9 overrun down", err_drive_o, 1'b0);
      chk("R9 overrun unlock", lock_pull_o, 1'b0);
      fb_at(6);
      step_to(7);
      chk("R9 stays unlocked", lock_pull_o, 1'b0);
      chk("R6 pulse ended", err_en_o, 1'b0);
      // coincident edges, unlocked: no pulse
      wait_ref();
      fb = 1'b1;
      step_to(1);
      fb = 1'b0;
      chk("R6 coincident no pulse", err_en_o, 1'b0);
      chk("R7 one good (coincident)", lock_pull_o, 1'b0);
      // feedback leads by 3
      fb_at(13);
      step_to(14);
      chk("R4 lead en", err_en_o, 1'b1);
      chk("R4 lead up", err_drive_o, 1'b1);
      wait_ref();
      step_to(1);
      chk("R7 locked after lead", lock_pull_o, 1'b1);
      // feedback at higher frequency
      wait_ref();
      fb_at(2);
      step_to(3);
      chk("R8 short down released", err_en_o, 1'b0);
      fb_at(6);
      step_to(10);
      chk("R8 up within window", err_en_o, 1'b0);
      step_to(11);
      chk("R4 fast fb en", err_en_o, 1'b1);
      chk("R4 fast fb up", err_drive_o, 1'b1);
      chk("R9 fast fb unlock", lock_pull_o, 1'b0);
      wait_ref();
      // reference at higher frequency (feedback missing)
      wait_ref();
      step_to(8);
      chk("R5 fast ref en", err_en_o, 1'b1);
      chk("R5 fast ref down", err_drive_o, 1'b0);
      step_to(17);
      chk("R5 second ref keeps down", err_drive_o, 1'b0);
      chk("R5 second ref en", err_en_o, 1'b1);
      fb_at(18);
      step_to(19);
      chk("R6 fb ends down", err_en_o, 1'b0);

      // divider reload behaviour
      while (exp_q.size() > 0) @(negedge clk);
      load_ratio(12, 16, 24, "R2");
      load_ratio(2, 24, 24, "R3");
      load_ratio(3, 24, 6, "R3 min");
      load_ratio(2047, 6, 4094, "R3 max");
      load_ratio(0, 4094, 4094, "R3 zero");

      summary();
      $finish;
   end
endmodule